// File: doc/BRIEF.md
# Debug Register Memory Access Engine

This block lets a debug host reach system memory through a small set of indexed registers. The host writes an address register and a control register over a parallel index/data port. Write accesses also need one or more words written to a data register. The engine then asks an external request/grant arbiter for the bus and performs the transfer as a bus master. When it finishes, it updates the error and data-valid status and pulses a ready output. The host can wait for that pulse instead of polling the status.

Single accesses of 8, 16, 32 and 64 bits are supported in both directions. Burst writes move 32 bytes as four 64-bit beats. Every host word is little-endian, so the engine reverses the byte order between the host port and the bus. A burst gathers all eight host words in an internal two-bank buffer before the first beat goes out. Only one bus transaction is ever outstanding.

Top module: `dbg_mem_engine`

## Requirements
- R1: Index 7 is control/status, index 9 is address, and index 10 is data; any other index reads as 0. The control word has these fields: start [0], map select [3:1], priority [5:4], write [6] (1 = write), size [9:7], count [23:10] and burst [24]. On a read of index 7, bits [24:0] return the stored control word with start shown as 0, bit 25 is error, bit 26 is data-valid and bit 27 is busy. After reset every register reads 0. Read data appears on `host_rdata` one cycle after `host_re`.
- R2: A control write with bit 0 set, made while idle, launches an access and clears error and data-valid. With bit 0 clear, the word is only stored and no bus activity follows. Map select, priority and count are stored but have no effect on the transfer.
- R3: A single write waits for one data-register write when the size is 000, 001 or 010, and for two when the size is 011 (64-bit). It then issues exactly one beat with `bus_we`=1, `bus_size` equal to the size field, and `bus_addr` equal to the address register.
- R4: Write byte order: an 8-bit write puts host bits [7:0] on `bus_wdata[7:0]`. A 16-bit write puts the host's two low bytes on bits [15:0] in reversed order. A 32-bit write puts the byte-reversed host word on bits [31:0]. For 64-bit data, the byte-reversed first word goes on bits [63:32] and the byte-reversed second word on bits [31:0]. Unused upper bits are 0, so host 0xEFBEADDE becomes bus value 0xDEADBEEF.
- R5: A single read (write=0) issues one beat with `bus_we`=0 immediately after launch, with no data writes needed. On success it sets data-valid. A data-register read then returns the returned data: for narrow sizes, the low bytes of `bus_rdata` reversed in the same way as R4 and zero-extended. For 64-bit reads, the first data read returns the reversed bits [63:32] and the second returns the reversed bits [31:0].
- R6: Data-valid clears on the host read of the last data word: the first data read for narrow sizes, the second for 64-bit.
- R7: A burst write (burst=1, write=1) is sent with size 011 whatever the size field holds. It waits for eight data writes, then issues four beats at the address with bits [2:0] forced to 0, plus 0, 8, 16 and 24. Beat k carries host words 2k and 2k+1 arranged as in R4.
- R8: `bus_req` rises after launch (for a write, after the last data word) and stays high until the access ends. `bus_cmd` rises only after `bus_gnt` was seen with `bus_req`, and address and data hold steady until the one-cycle `bus_done`.
- R9: When an access ends without error, error is 0, data-valid is 1 after a read and 0 after a write, busy is 0, and `rdy` is high for exactly one cycle.
- R10: A `bus_done` with `bus_err` set ends the access at once, and no further beats of a burst are issued. Error becomes 1 and stays set until the next launch, data-valid is 0, and `rdy` stays low.
- R11: While busy, writes to the control and address registers are ignored. Data-register writes only count while an access is collecting write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_idx | input | 4 | Register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| rdy | output | 1 | One-cycle pulse on error-free completion |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_cmd | output | 1 | Beat address/data/control valid |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_we | output | 1 | 1 = write beat |
| bus_size | output | 3 | Beat size code |
| bus_wdata | output | 64 | Beat write data |
| bus_done | input | 1 | One-cycle beat completion |
| bus_err | input | 1 | Error qualifier with bus_done |
| bus_rdata | input | 64 | Read data, valid with bus_done |

## Verification
The bench sweeps every size against several addresses and map/priority settings in both directions, and every low-address offset of a burst. Byte-lane mistakes show up as swapped or shifted bytes on `bus_wdata` or in the data readback, and an alignment mistake puts burst beats at the wrong address. It injects an error on each of the four burst beats in turn: an engine that kept going would issue extra beats, raise `rdy`, or leave data-valid set. It also checks that a 64-bit access waits for its second word and keeps data-valid across the first data read, and that address and control writes made during a burst fill leave both the bus address and the readback untouched.

// File: rtl/dme_pkg.sv
package dme_pkg;

  localparam logic [2:0] SZ_8  = 3'b000;
  localparam logic [2:0] SZ_16 = 3'b001;
  localparam logic [2:0] SZ_32 = 3'b010;
  localparam logic [2:0] SZ_64 = 3'b011;

  localparam int CTRL_W = 25;

  typedef struct packed {
    logic        burst;
    logic [13:0] cnt;
    logic [2:0]  size;
    logic        wr;
    logic [1:0]  prio;
    logic [2:0]  map;
    logic        start;
  } ctrl_t;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // reverse the low bytes that belong to a narrow access, zero the rest
  function automatic logic [31:0] lane_swap(input logic [31:0] w, input logic [2:0] sz);
    case (sz)
      SZ_8:    return {24'b0, w[7:0]};
      SZ_16:   return {16'b0, w[7:0], w[15:8]};
      default: return bswap32(w);
    endcase
  endfunction

endpackage

// File: rtl/dme_wordbuf.sv
module dme_wordbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dme_regfile.sv
module dme_regfile
  import dme_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int CTRL_IDX = 7,
  parameter int ADDR_IDX = 9,
  parameter int DATA_IDX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic              fin_ok,
  input  logic              fin_err,
  input  logic              fin_rd,
  input  logic [31:0]       rword0,
  input  logic [31:0]       rword1,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              launch,
  output logic              dwr,
  output logic              err_q,
  output logic              dv_q
);
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] I_ADDR = IDX_W'(ADDR_IDX);
  localparam logic [IDX_W-1:0] I_DATA = IDX_W'(DATA_IDX);

  logic rptr;
  logic wide;

  assign wide   = (ctrl_q.size == SZ_64);
  assign launch = host_we && host_idx == I_CTRL && host_wdata[0] && !busy;
  assign dwr    = host_we && host_idx == I_DATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      addr_q     <= '0;
      err_q      <= 1'b0;
      dv_q       <= 1'b0;
      rptr       <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_we && !busy) begin
        if (host_idx == I_CTRL) ctrl_q <= ctrl_t'({host_wdata[CTRL_W-1:1], 1'b0});
        if (host_idx == I_ADDR) addr_q <= host_wdata[ADDR_W-1:0];
      end
      if (launch) begin
        err_q <= 1'b0;
        dv_q  <= 1'b0;
        rptr  <= 1'b0;
      end else if (fin_err) begin
        err_q <= 1'b1;
        dv_q  <= 1'b0;
      end else if (fin_ok) begin
        err_q <= 1'b0;
        dv_q  <= fin_rd;
        rptr  <= 1'b0;
      end else if (host_re && host_idx == I_DATA) begin
        rptr <= wide ? !rptr : 1'b0;
        if (rptr == wide) dv_q <= 1'b0;
      end
      if (host_re) begin
        case (host_idx)
          I_CTRL:  host_rdata <= {4'b0, busy, dv_q, err_q, ctrl_q};
          I_ADDR:  host_rdata <= 32'(addr_q);
          I_DATA:  host_rdata <= rptr ? rword1 : rword0;
          default: host_rdata <= '0;
        endcase
      end
    end
  end

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(ctrl_q) && $stable(addr_q)); // R11
  AST_ERR_NO_DV: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !dv_q); // R10
endmodule

// File: rtl/dme_seq.sv
module dme_seq
  import dme_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_WORDS = 8,
  localparam int BEATS      = BURST_WORDS / 2,
  localparam int WPW        = $clog2(BURST_WORDS),
  localparam int BW         = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_wr,
  input  logic              c_wr,
  input  logic [2:0]        c_size,
  input  logic              c_burst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dwr,
  input  logic [31:0]       dwdata,
  output logic              busy,
  output logic              rdy,
  output logic              fin_ok,
  output logic              fin_err,
  output logic              fin_rd,
  output logic [1:0]        bk_we,
  output logic [BW-1:0]     bk_widx,
  output logic [1:0][31:0]  bk_wd,
  output logic [BW-1:0]     bk_ridx,
  input  logic [1:0][31:0]  bk_rd,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [2:0]        bus_size,
  output logic [63:0]       bus_wdata,
  input  logic              bus_done,
  input  logic              bus_err,
  input  logic [63:0]       bus_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_REQ, S_BUS} st_t;

  st_t            st;
  logic [WPW-1:0] wptr;
  logic [BW-1:0]  beat;
  logic [WPW-1:0] last_w;
  logic           burst_m;
  logic           wide;
  logic           last_beat;
  logic           rd_done;
  logic           fill_wr;

  assign burst_m   = c_burst && c_wr;
  assign wide      = burst_m || c_size == SZ_64;
  assign last_beat = !burst_m || beat == BW'(BEATS - 1);

  always_comb begin
    if (burst_m)             last_w = WPW'(BURST_WORDS - 1);
    else if (c_size == SZ_64) last_w = WPW'(1);
    else                     last_w = '0;
  end

  assign fin_ok  = st == S_BUS && bus_done && !bus_err && last_beat;
  assign fin_err = st == S_BUS && bus_done && bus_err;
  assign fin_rd  = !c_wr;
  assign rd_done = st == S_BUS && bus_done && !bus_err && !c_wr;
  assign fill_wr = st == S_FILL && dwr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      wptr <= '0;
      beat <= '0;
      rdy  <= 1'b0;
    end else begin
      rdy <= fin_ok;
      case (st)
        S_IDLE: if (launch) begin
          wptr <= '0;
          beat <= '0;
          st   <= launch_wr ? S_FILL : S_REQ;
        end
        S_FILL: if (dwr) begin
          wptr <= wptr + 1'b1;
          if (wptr == last_w) st <= S_REQ;
        end
        S_REQ: if (bus_gnt) st <= S_BUS;
        S_BUS: if (bus_done) begin
          if (bus_err || last_beat) st <= S_IDLE;
          else beat <= beat + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign bus_req  = st == S_REQ || st == S_BUS;
  assign bus_cmd  = st == S_BUS;
  assign bus_we   = c_wr;
  assign bus_size = burst_m ? SZ_64 : c_size;
  assign bus_addr = burst_m ? ({addr[ADDR_W-1:3], 3'b000} + (ADDR_W'(beat) << 3)) : addr;
  assign bk_ridx  = beat;

  always_comb begin
    if (wide) bus_wdata = {bswap32(bk_rd[0]), bswap32(bk_rd[1])};
    else      bus_wdata = {32'b0, lane_swap(bk_rd[0], c_size)};
  end

  // buffer write ports: host words during fill, returned data on a read
  assign bk_widx  = rd_done ? '0 : wptr[WPW-1:1];
  assign bk_we[0] = rd_done || (fill_wr && !wptr[0]);
  assign bk_we[1] = rd_done || (fill_wr && wptr[0]);
  assign bk_wd[0] = rd_done ? (c_size == SZ_64 ? bswap32(bus_rdata[63:32])
                                               : lane_swap(bus_rdata[31:0], c_size))
                            : dwdata;
  assign bk_wd[1] = rd_done ? bswap32(bus_rdata[31:0]) : dwdata;

  AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cmd) |-> $past(bus_req) && $past(bus_gnt)); // R8
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_cmd && $past(bus_cmd) && !$past(bus_done) |-> $stable(bus_addr) && $stable(bus_wdata)); // R8
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    bus_cmd && $past(bus_cmd) && $past(bus_done) |-> bus_addr == $past(bus_addr) + ADDR_W'(8)); // R7
  AST_STOP_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    bus_done && bus_err |=> !bus_req); // R10
endmodule

// File: rtl/dbg_mem_engine.sv
module dbg_mem_engine
  import dme_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int BURST_WORDS = 8,
  localparam int BEATS      = BURST_WORDS / 2,
  localparam int BW         = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              rdy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [2:0]        bus_size,
  output logic [63:0]       bus_wdata,
  input  logic              bus_done,
  input  logic              bus_err,
  input  logic [63:0]       bus_rdata
);
  ctrl_t              ctrl_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               launch, dwr, busy, fin_ok, fin_err, fin_rd, err_q, dv_q;
  logic [1:0]         bk_we;
  logic [BW-1:0]      bk_widx, bk_ridx;
  logic [1:0][31:0]   bk_wd, bk_rd, bk_r0;
  ctrl_t              wctrl;

  assign wctrl = ctrl_t'(host_wdata[CTRL_W-1:0]);

  dme_regfile #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .fin_ok(fin_ok), .fin_err(fin_err), .fin_rd(fin_rd),
    .rword0(bk_r0[0]), .rword1(bk_r0[1]), .ctrl_q(ctrl_q), .addr_q(addr_q),
    .launch(launch), .dwr(dwr), .err_q(err_q), .dv_q(dv_q)
  );

  dme_seq #(.ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .launch_wr(wctrl.wr),
    .c_wr(ctrl_q.wr), .c_size(ctrl_q.size), .c_burst(ctrl_q.burst), .addr(addr_q),
    .dwr(dwr), .dwdata(host_wdata), .busy(busy), .rdy(rdy),
    .fin_ok(fin_ok), .fin_err(fin_err), .fin_rd(fin_rd),
    .bk_we(bk_we), .bk_widx(bk_widx), .bk_wd(bk_wd), .bk_ridx(bk_ridx), .bk_rd(bk_rd),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  // even bank holds words 0,2,4,6; odd bank holds 1,3,5,7
  for (genvar g = 0; g < 2; g++) begin : g_bank
    dme_wordbuf #(.DEPTH(BEATS), .W(32)) u_bank (
      .clk(clk), .we(bk_we[g]), .waddr(bk_widx), .wdata(bk_wd[g]),
      .raddr_a(bk_ridx), .rdata_a(bk_rd[g]),
      .raddr_b('0), .rdata_b(bk_r0[g])
    );
  end

  AST_RDY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !err_q && !busy); // R9
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy); // R9
endmodule

// File: tb/dbg_mem_engine_test.sv
`timescale 1ns/1ps
module dbg_mem_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 0, host_re = 0;
  logic [3:0]  host_idx = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        rdy, bus_req, bus_cmd, bus_we;
  logic        bus_gnt = 0, bus_done = 0, bus_err = 0;
  logic [31:0] bus_addr;
  logic [2:0]  bus_size;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata = 0;

  int vectors = 0, fails = 0;
  int nbeats = 0, rdy_cnt = 0, err_beat = -1, gcnt = 0, wcnt = 0;
  logic [31:0] log_a [8];
  logic [63:0] log_d [8];
  logic        log_we [8];
  logic [2:0]  log_sz [8];

  always #2.5 clk = ~clk;

  dbg_mem_engine uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rdy(rdy),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] bs(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] lane(input logic [31:0] w, input int s);
    if (s == 0) return {24'b0, w[7:0]};
    if (s == 1) return {16'b0, w[7:0], w[15:8]};
    return bs(w);
  endfunction
  function automatic logic [63:0] mem_val(input logic [31:0] a);
    return {a ^ 32'h1357_2468, a + 32'h0F0F_0F0F};
  endfunction
  function automatic logic [31:0] mk(input int st, input int map, input int pr,
                                     input int wr, input int sz, input int bu);
    return {7'b0, 1'(bu), 14'd4, 3'(sz), 1'(wr), 2'(pr), 3'(map), 1'(st)};
  endfunction

  // arbiter: grant two cycles after request
  always @(negedge clk) begin
    if (!bus_req) begin bus_gnt = 0; gcnt = 0; end
    else if (gcnt >= 2) bus_gnt = 1;
    else gcnt++;
  end

  // memory slave: latency 1..3, one-cycle done
  always @(negedge clk) begin
    if (bus_done) begin bus_done = 0; bus_err = 0; wcnt = 0; end
    else if (!rst && bus_cmd) begin
      if (wcnt >= 1 + (nbeats % 3)) begin
        if (nbeats < 8) begin
          log_a[nbeats] = bus_addr; log_d[nbeats] = bus_wdata;
          log_we[nbeats] = bus_we; log_sz[nbeats] = bus_size;
        end
        bus_rdata = mem_val(bus_addr);
        bus_err = (nbeats == err_beat);
        bus_done = 1;
        nbeats++;
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  always @(negedge clk) if (!rst && rdy) rdy_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input int idx, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_idx = 4'(idx); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hr(input int idx, output logic [31:0] d);
    @(negedge clk); host_re = 1; host_idx = 4'(idx);
    @(negedge clk); host_re = 0; d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      hr(7, s);
      if (!s[27]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, a, w0, w1, st0;
    logic [31:0] bw [8];
    int r0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    hr(7, d); chk("R1 ctrl reset", d, 0);
    hr(9, d); chk("R1 addr reset", d, 0);
    hr(3, d); chk("R1 unused index", d, 0);
    chk("R1 bus_req reset", bus_req, 0);

    // R2 start bit clear only stores; idle data write ignored (R11)
    hw(9, 32'h0000_1234);
    hw(7, mk(0, 5, 2, 1, 2, 0));
    hw(10, 32'h1111_2222);
    repeat (20) @(negedge clk);
    chk("R2 no launch beats", nbeats, 0);
    hr(7, d); chk("R2/R1 stored ctrl", d, mk(0, 5, 2, 1, 2, 0));
    hr(9, d); chk("R1 addr readback", d, 32'h0000_1234);

    // R3 R4 single writes, all sizes, map/priority swept (R2)
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 3; k++) begin
        a  = 32'h2000_0000 + 32'(k * 13 + s);
        w0 = (s == 2 && k == 0) ? 32'hEFBE_ADDE : 32'h0123_4567 * (k + 1) + 32'(s);
        w1 = ~w0 ^ 32'(k);
        nbeats = 0; r0 = rdy_cnt;
        hw(9, a);
        hw(7, mk(1, (k + s) % 8, k, 1, s, 0));
        hw(10, w0);
        if (s == 3) begin
          repeat (10) @(negedge clk);
          chk("R3 64-bit waits second word", nbeats, 0);
          hw(10, w1);
        end
        wait_idle();
        chk("R3 one beat", nbeats, 1);
        chk("R3 addr", log_a[0], a);
        chk("R3 size", log_sz[0], 3'(s));
        chk("R3 we", log_we[0], 1);
        if (s == 3) chk("R4 data64", log_d[0], {bs(w0), bs(w1)});
        else        chk("R4 data", log_d[0], {32'b0, lane(w0, s)});
        if (s == 2 && k == 0) chk("R4 deadbeef", log_d[0], 64'h0000_0000_DEAD_BEEF);
        chk("R9 rdy pulse", rdy_cnt - r0, 1);
        hr(7, d); chk("R9 status after write", d[27:25], 3'b000);
      end
    end

    // R5 R6 single reads
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 3; k++) begin
        a = 32'h3000_0100 + 32'(k * 4 + s);
        nbeats = 0; r0 = rdy_cnt;
        hw(9, a);
        hw(7, mk(1, k, 3 - k, 0, s, 0));
        wait_idle();
        chk("R5 one beat", nbeats, 1);
        chk("R5 read we", log_we[0], 0);
        chk("R5 read addr", log_a[0], a);
        chk("R5 read size", log_sz[0], 3'(s));
        chk("R9 rdy on read", rdy_cnt - r0, 1);
        hr(7, d); chk("R9 dv set err clear", d[26:25], 2'b10);
        hr(10, d);
        if (s == 3) begin
          chk("R5 read word0", d, bs(mem_val(a)[63:32]));
          hr(7, d); chk("R6 dv kept mid 64", d[26], 1);
          hr(10, d); chk("R5 read word1", d, bs(mem_val(a)[31:0]));
        end else chk("R5 read narrow", d, lane(mem_val(a)[31:0], s));
        hr(7, d); chk("R6 dv cleared", d[26], 0);
      end
    end

    // R7 bursts, every low-address offset; R11 writes during fill ignored
    for (int lo = 0; lo < 8; lo++) begin
      a = 32'h4000_0200 + 32'(lo * 32 + lo);
      nbeats = 0; r0 = rdy_cnt;
      hw(9, a);
      hw(7, mk(1, 0, 0, 1, lo % 3, 1));
      for (int i = 0; i < 8; i++) begin
        bw[i] = 32'h1111_1111 * 32'(i + 1) ^ 32'(lo << 8);
        hw(10, bw[i]);
        if (i == 3 && lo == 3) begin
          hw(9, 32'hFFFF_FFF0);
          hw(7, mk(1, 0, 0, 0, 0, 0));
        end
        if (i == 6) chk("R7 buffered before bus", nbeats, 0);
      end
      wait_idle();
      chk("R7 four beats", nbeats, 4);
      for (int b = 0; b < 4; b++) begin
        chk("R7 beat addr", log_a[b], (a & ~32'h7) + 32'(8 * b));
        chk("R7 beat data", log_d[b], {bs(bw[2 * b]), bs(bw[2 * b + 1])});
        chk("R7 beat size", log_sz[b], 3'b011);
      end
      chk("R9 burst rdy", rdy_cnt - r0, 1);
      if (lo == 3) begin
        hr(9, d); chk("R11 addr kept", d, a);
        hr(7, d); chk("R11 ctrl kept", d[24:0], 25'(mk(0, 0, 0, 1, 0, 1)));
      end
    end

    // R10 error on each burst beat
    for (int eb = 0; eb < 4; eb++) begin
      nbeats = 0; r0 = rdy_cnt; err_beat = eb;
      hw(9, 32'h5000_0000 + 32'(eb * 64));
      hw(7, mk(1, 0, 0, 1, 3, 1));
      for (int i = 0; i < 8; i++) hw(10, 32'(i));
      wait_idle();
      repeat (10) @(negedge clk);
      chk("R10 beats abandoned", nbeats, eb + 1);
      chk("R10 no rdy", rdy_cnt - r0, 0);
      hr(7, d); chk("R10 err set dv clear", d[27:25], 3'b001);
      chk("R10 bus released", bus_req, 0);
    end

    // R10 read error keeps dv low; error persists until next launch
    nbeats = 0; err_beat = 0;
    hw(9, 32'h6000_0004);
    hw(7, mk(1, 0, 0, 0, 2, 0));
    wait_idle();
    hr(7, st0); chk("R10 read err status", st0[26:25], 2'b01);
    hw(9, 32'h6000_0008);
    hr(7, d); chk("R10 err persists", d[25], 1);
    err_beat = -1; nbeats = 0;
    hw(7, mk(1, 0, 0, 1, 0, 0));
    hw(10, 32'h0000_00A5);
    wait_idle();
    hr(7, d); chk("R10 err cleared by launch", d[26:25], 2'b00);
    chk("R4 byte write", log_d[0], 64'h0000_0000_0000_00A5);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule